// File: doc/BRIEF.md
# Link Reset and Power-Down Sequencer

This block is the control logic for one point-to-point link. It works out whether a reset is cold or warm. It also moves the link transmitter through an orderly disconnect and a later reconnect for power management.

A reset is cold when power-good is low as the reset input goes low, and warm when power-good is already high. Software can also request a reset and pick its kind. When the stop input asserts, the sequencer first lets any control packet that is in flight finish. It then asks for a disconnect NOP sequence of fixed length and parks the link. While parked, the output drivers are turned off only if the transmit tri-state option is set. Releasing the stop input turns the drivers back on and starts one link initialization.

The receiver path is handled on its own. It shuts its inputs off after it sees a disconnect sequence, but only if its own tri-state option is set. A wire-OR style wake request asks system logic to release the stop input when a transaction is waiting on a parked link.

Top module: `link_pm_seq`

## Requirements
- R1: While `reset_n` is low and `pwr_ok` is low, `rst_kind` becomes 2'b10 (cold) one cycle later. It stays cold for the rest of that reset, even if `pwr_ok` rises before `reset_n` is released.
- R2: A fall of `reset_n` sampled while `pwr_ok` is high sets `rst_kind` to 2'b01 (warm) one cycle later.
- R3: A one-cycle `sw_rst_req` enters the reset state on the next cycle. It sets `rst_kind` to 2'b10 if `sw_rst_cold` is 1, or to 2'b01 if it is 0. Once the request drops, the link restarts.
- R4: While reset is active, or one cycle after `pwr_ok` is sampled low, the following are all low: `tx_drv_en`, `rx_rcv_en`, `init_start` and `disc_nop_req`. `rst_active` is 1.
- R5: In the active state, a low `stop_n` with no control packet in progress raises `disc_nop_req` on the next cycle. It then stays high for exactly NOP_LEN consecutive cycles before the link parks.
- R6: If `ctl_pkt_busy` is high when `stop_n` is seen low, `disc_nop_req` stays low until `ctl_pkt_end` is sampled high. It rises on the cycle after that.
- R7: While parked, `tx_drv_en` is 0 if `tx_tri_en` is 1, and 1 if `tx_tri_en` is 0.
- R8: With `stop_n` low, a sampled `rx_disc_seen` drops `rx_rcv_en` on the next cycle only when `rx_tri_en` is 1. When `rx_tri_en` is 0 it has no effect. `rx_rcv_en` returns to 1 one cycle after `stop_n` is sampled high.
- R9: In the parked state, a high `stop_n` gives, on the next cycle, `tx_drv_en`=1 and a one-cycle `init_start` pulse. The link then returns to the active state.
- R10: `req_n` goes low one cycle after `xact_pending` is sampled high while parked with `stop_n` low. It returns high one cycle after `stop_n` is sampled high. It is never low while the link is active.
- R11: A low `reset_n` forces the reset state on the next cycle from any state, including mid-disconnect, and ends `disc_nop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link control clock |
| pwr_ok | input | 1 | Power and clocks within limits |
| reset_n | input | 1 | Active-low link reset, sampled synchronously |
| stop_n | input | 1 | Active-low link stop request from system logic |
| sw_rst_req | input | 1 | Software reset request pulse |
| sw_rst_cold | input | 1 | Software reset kind: 1 cold, 0 warm |
| tx_tri_en | input | 1 | Allow turning transmit drivers off while parked |
| rx_tri_en | input | 1 | Allow turning receivers off after a disconnect |
| ctl_pkt_busy | input | 1 | A control packet is being transmitted |
| ctl_pkt_end | input | 1 | Last bit time of the current control packet |
| rx_disc_seen | input | 1 | Receiver detected a disconnect NOP sequence |
| xact_pending | input | 1 | A transaction waits for the link |
| rst_kind | output | 2 | 2'b01 warm, 2'b10 cold |
| rst_active | output | 1 | Sequencer is in its reset state |
| disc_nop_req | output | 1 | Emit disconnect NOP bit times |
| tx_drv_en | output | 1 | Transmit output drivers enabled |
| rx_rcv_en | output | 1 | Receive input buffers enabled |
| init_start | output | 1 | One-cycle pulse starting link initialization |
| req_n | output | 1 | Active-low wake request, wire-OR style |

## Verification
The ports reveal a wrong internal state within one cycle. Outputs are decoded directly from the state register, so an off-by-one in the disconnect counter shows as a `disc_nop_req` burst that is one cycle too long or too short. An early leave from the drain state shows as `disc_nop_req` rising while `ctl_pkt_busy` is still high. A stuck receiver-off flag shows as `rx_rcv_en` staying low on the cycle after `stop_n` rises. A misclassified reset is visible on `rst_kind` on the cycle after the reset edge.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;

  localparam int S_RESET   = 0;
  localparam int S_ACTIVE  = 1;
  localparam int S_DRAIN   = 2;
  localparam int S_DISC    = 3;
  localparam int S_STOPPED = 4;
  localparam int S_REINIT  = 5;

  typedef enum logic [5:0] {
    ST_RESET   = 6'b000001,
    ST_ACTIVE  = 6'b000010,
    ST_DRAIN   = 6'b000100,
    ST_DISC    = 6'b001000,
    ST_STOPPED = 6'b010000,
    ST_REINIT  = 6'b100000
  } pm_state_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'b00,
    RK_WARM = 2'b01,
    RK_COLD = 2'b10
  } rst_kind_e;

  // counter width able to hold 0 .. len-1
  function automatic int unsigned cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction

  // transmit drivers are on in every live state; parked only without tri-state
  function automatic logic drv_on(input logic [5:0] st, input logic tri_en);
    return st[S_ACTIVE] | st[S_DRAIN] | st[S_DISC] | st[S_REINIT] |
           (st[S_STOPPED] & ~tri_en);
  endfunction

endpackage

// File: rtl/lps_rst_classify.sv
module lps_rst_classify
  import link_pm_pkg::*;
(
  input  logic      clk,
  input  logic      reset_n,
  input  logic      pwr_ok,
  input  logic      sw_req,
  input  logic      sw_cold,
  output rst_kind_e kind
);

  logic      reset_n_q;
  rst_kind_e kind_q;

  // a fall of reset_n is the instant the kind is decided
  logic reset_fall;
  assign reset_fall = !reset_n && reset_n_q;

  always_ff @(posedge clk) begin
    reset_n_q <= reset_n;
    if (!reset_n) begin
      if (!pwr_ok)         kind_q <= RK_COLD;
      else if (reset_fall) kind_q <= RK_WARM;
    end else if (sw_req) begin
      kind_q <= sw_cold ? RK_COLD : RK_WARM;
    end
  end

  assign kind = kind_q;

  assert_cold_R1: assert property (@(posedge clk)
    (!reset_n && !pwr_ok) |=> kind_q == RK_COLD);

  assert_warm_R2: assert property (@(posedge clk)
    (reset_fall && pwr_ok) |=> kind_q == RK_WARM);

  assert_sw_kind_R3: assert property (@(posedge clk) disable iff (!reset_n)
    sw_req |=> kind_q == (sw_cold ? RK_COLD : RK_WARM));

endmodule

// File: rtl/lps_disc_count.sv
module lps_disc_count
  import link_pm_pkg::*;
#(
  parameter int unsigned NOP_LEN = 64
) (
  input  logic clk,
  input  logic run,
  output logic last
);

  localparam int unsigned CW = cnt_width(NOP_LEN);
  localparam logic [CW-1:0] LAST_VAL = CW'(NOP_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!run)                  cnt_q <= '0;
    else if (cnt_q != LAST_VAL) cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == LAST_VAL);

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import link_pm_pkg::*;
(
  input  logic      clk,
  input  logic      reset_n,
  input  logic      pwr_ok,
  input  logic      sw_req,
  input  logic      stop_n,
  input  logic      ctl_busy,
  input  logic      ctl_end,
  input  logic      disc_last,
  output pm_state_e state
);

  pm_state_e state_q, state_d;
  logic force_reset;

  assign force_reset = !reset_n || !pwr_ok || sw_req;

  always_comb begin
    state_d = state_q;
    if (force_reset) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET:   state_d = ST_REINIT;
        ST_REINIT:  state_d = ST_ACTIVE;
        ST_ACTIVE:  if (!stop_n) state_d = (ctl_busy && !ctl_end) ? ST_DRAIN : ST_DISC;
        ST_DRAIN:   if (ctl_end) state_d = ST_DISC;
        ST_DISC:    if (disc_last) state_d = ST_STOPPED;
        ST_STOPPED: if (stop_n) state_d = ST_REINIT;
        default:    state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) state_q <= state_d;

  assign state = state_q;

  assert_onehot_R11: assert property (@(posedge clk) disable iff (!reset_n)
    $countones(state_q) == 1);

  assert_override_R11: assert property (@(posedge clk)
    !reset_n |=> state_q == ST_RESET);

  assert_pwr_gate_R4: assert property (@(posedge clk) disable iff (!reset_n)
    !pwr_ok |=> state_q == ST_RESET);

  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!reset_n)
    (state_q == ST_DRAIN && !ctl_end && pwr_ok && !sw_req) |=> state_q == ST_DRAIN);

  assert_reinit_R9: assert property (@(posedge clk) disable iff (!reset_n)
    (state_q == ST_STOPPED && stop_n && pwr_ok && !sw_req) |=> state_q == ST_REINIT);

endmodule

// File: rtl/link_pm_seq.sv
module link_pm_seq
  import link_pm_pkg::*;
#(
  parameter int unsigned NOP_LEN = 64,
  parameter bit          HAS_REQ = 1'b1
) (
  input  logic       clk,
  input  logic       pwr_ok,
  input  logic       reset_n,
  input  logic       stop_n,
  input  logic       sw_rst_req,
  input  logic       sw_rst_cold,
  input  logic       tx_tri_en,
  input  logic       rx_tri_en,
  input  logic       ctl_pkt_busy,
  input  logic       ctl_pkt_end,
  input  logic       rx_disc_seen,
  input  logic       xact_pending,
  output logic [1:0] rst_kind,
  output logic       rst_active,
  output logic       disc_nop_req,
  output logic       tx_drv_en,
  output logic       rx_rcv_en,
  output logic       init_start,
  output logic       req_n
);

  pm_state_e state;
  rst_kind_e kind;
  logic      disc_last;
  logic      rx_off_q;

  // named state events for the checks below
  logic st_reset, st_active, st_disc, st_stopped, st_reinit;
  assign st_reset   = state[S_RESET];
  assign st_active  = state[S_ACTIVE];
  assign st_disc    = state[S_DISC];
  assign st_stopped = state[S_STOPPED];
  assign st_reinit  = state[S_REINIT];

  lps_rst_classify u_classify (
    .clk     (clk),
    .reset_n (reset_n),
    .pwr_ok  (pwr_ok),
    .sw_req  (sw_rst_req),
    .sw_cold (sw_rst_cold),
    .kind    (kind)
  );

  lps_disc_count #(.NOP_LEN(NOP_LEN)) u_count (
    .clk  (clk),
    .run  (st_disc),
    .last (disc_last)
  );

  lps_fsm u_fsm (
    .clk       (clk),
    .reset_n   (reset_n),
    .pwr_ok    (pwr_ok),
    .sw_req    (sw_rst_req),
    .stop_n    (stop_n),
    .ctl_busy  (ctl_pkt_busy),
    .ctl_end   (ctl_pkt_end),
    .disc_last (disc_last),
    .state     (state)
  );

  // receiver side: off only after a disconnect and with its own tri-state bit
  always_ff @(posedge clk) begin
    if (!reset_n || stop_n)                    rx_off_q <= 1'b0;
    else if (rx_disc_seen && rx_tri_en)        rx_off_q <= 1'b1;
  end

  generate
    if (HAS_REQ) begin : g_req
      logic req_q;
      always_ff @(posedge clk) begin
        if (!reset_n) req_q <= 1'b0;
        else          req_q <= st_stopped && !stop_n && xact_pending;
      end
      assign req_n = ~req_q;
    end else begin : g_no_req
      assign req_n = 1'b1;
    end
  endgenerate

  assign rst_kind     = kind;
  assign rst_active   = st_reset;
  assign disc_nop_req = st_disc;
  assign init_start   = st_reinit;
  assign tx_drv_en    = drv_on(state, tx_tri_en);
  assign rx_rcv_en    = !st_reset && !rx_off_q;

  // checker-side burst length counter
  logic [31:0] chk_disc_len;
  always_ff @(posedge clk) begin
    if (!reset_n || !disc_nop_req) chk_disc_len <= '0;
    else                            chk_disc_len <= chk_disc_len + 1'b1;
  end

  assert_disc_len_R5: assert property (@(posedge clk) disable iff (!reset_n)
    ($fell(disc_nop_req) && st_stopped) |-> chk_disc_len == NOP_LEN);

  assert_req_idle_R10: assert property (@(posedge clk) disable iff (!reset_n)
    st_active |-> req_n);

  assert_req_release_R10: assert property (@(posedge clk) disable iff (!reset_n)
    stop_n |=> req_n);

  assert_rx_back_R8: assert property (@(posedge clk) disable iff (!reset_n)
    (stop_n && pwr_ok && !sw_rst_req) |=> rx_rcv_en);

  assert_tri_R7: assert property (@(posedge clk) disable iff (!reset_n)
    ($fell(disc_nop_req) && st_stopped) |-> tx_drv_en == !tx_tri_en);

  assert_quiet_R4: assert property (@(posedge clk)
    st_reset |-> !(tx_drv_en || init_start || disc_nop_req || rx_rcv_en));

endmodule

// File: tb/link_pm_seq_tb.sv
module link_pm_seq_tb;

  localparam int unsigned LEN = 16;

  logic clk = 1'b0;
  logic pwr_ok = 1'b0, reset_n = 1'b0, stop_n = 1'b1;
  logic sw_rst_req = 1'b0, sw_rst_cold = 1'b0;
  logic tx_tri_en = 1'b0, rx_tri_en = 1'b0;
  logic ctl_pkt_busy = 1'b0, ctl_pkt_end = 1'b0;
  logic rx_disc_seen = 1'b0, xact_pending = 1'b0;
  logic [1:0] rst_kind;
  logic rst_active, disc_nop_req, tx_drv_en, rx_rcv_en, init_start, req_n;

  int total = 0;
  int bad = 0;

  localparam logic [1:0] K_WARM = 2'b01;
  localparam logic [1:0] K_COLD = 2'b10;

  always #5 clk = ~clk;

  link_pm_seq #(.NOP_LEN(LEN)) u_dut (
    .clk(clk), .pwr_ok(pwr_ok), .reset_n(reset_n), .stop_n(stop_n),
    .sw_rst_req(sw_rst_req), .sw_rst_cold(sw_rst_cold),
    .tx_tri_en(tx_tri_en), .rx_tri_en(rx_tri_en),
    .ctl_pkt_busy(ctl_pkt_busy), .ctl_pkt_end(ctl_pkt_end),
    .rx_disc_seen(rx_disc_seen), .xact_pending(xact_pending),
    .rst_kind(rst_kind), .rst_active(rst_active), .disc_nop_req(disc_nop_req),
    .tx_drv_en(tx_drv_en), .rx_rcv_en(rx_rcv_en), .init_start(init_start),
    .req_n(req_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // restated: parked drivers follow the inverse of the tri-state bit
  function automatic logic parked_drive(input logic tri_bit);
    return !tri_bit;
  endfunction

  task automatic t_cold_bringup();
    step(3);
    chk("R1", "kind cold", rst_kind, K_COLD);
    chk("R4", "rst_active", rst_active, 1);
    chk("R4", "tx off", tx_drv_en, 0);
    chk("R4", "rx off", rx_rcv_en, 0);
    chk("R4", "no init", init_start, 0);
    chk("R10", "req idle", req_n, 1);
    pwr_ok = 1'b1;
    step(1);
    chk("R1", "kind stays cold", rst_kind, K_COLD);
    chk("R4", "still reset", rst_active, 1);
    reset_n = 1'b1;
    step(1);
    chk("R9", "init pulse", init_start, 1);
    chk("R9", "tx on", tx_drv_en, 1);
    chk("R8", "rx on", rx_rcv_en, 1);
    step(1);
    chk("R9", "init ends", init_start, 0);
  endtask

  task automatic t_warm();
    reset_n = 1'b0;
    step(1);
    chk("R2", "kind warm", rst_kind, K_WARM);
    chk("R4", "tx off in reset", tx_drv_en, 0);
    reset_n = 1'b1;
    step(1);
    chk("R4", "restart", init_start, 1);
    step(1);
  endtask

  task automatic t_sw(input logic cold);
    sw_rst_req = 1'b1; sw_rst_cold = cold;
    step(1);
    sw_rst_req = 1'b0;
    chk("R3", "sw kind", rst_kind, cold ? K_COLD : K_WARM);
    chk("R3", "sw reset entered", rst_active, 1);
    step(1);
    chk("R3", "sw restart", init_start, 1);
    step(1);
  endtask

  task automatic t_pwr_drop();
    pwr_ok = 1'b0;
    step(1);
    chk("R4", "pwr low resets", rst_active, 1);
    chk("R4", "pwr low tx off", tx_drv_en, 0);
    step(2);
    chk("R4", "pwr low no init", init_start, 0);
    pwr_ok = 1'b1;
    step(1);
    chk("R4", "pwr back init", init_start, 1);
    step(1);
  endtask

  task automatic t_stop(input logic tri_bit);
    int n;
    tx_tri_en = tri_bit;
    xact_pending = 1'b1;
    step(1);
    chk("R10", "no req while active", req_n, 1);
    xact_pending = 1'b0;
    stop_n = 1'b0;
    step(1);
    chk("R5", "disc starts", disc_nop_req, 1);
    chk("R5", "tx on during disc", tx_drv_en, 1);
    n = 1;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (!disc_nop_req) break;
      n++;
    end
    chk("R5", "disc length", n, LEN);
    chk("R7", "parked drive", tx_drv_en, parked_drive(tri_bit));
    xact_pending = 1'b1;
    step(1);
    chk("R10", "wake request", req_n, 0);
    stop_n = 1'b1;
    step(1);
    chk("R10", "wake released", req_n, 1);
    chk("R9", "reinit pulse", init_start, 1);
    chk("R9", "tx back on", tx_drv_en, 1);
    xact_pending = 1'b0;
    step(1);
    chk("R9", "active again", init_start, 0);
  endtask

  task automatic t_drain();
    ctl_pkt_busy = 1'b1;
    stop_n = 1'b0;
    step(1);
    chk("R6", "deferred", disc_nop_req, 0);
    step(3);
    chk("R6", "still deferred", disc_nop_req, 0);
    ctl_pkt_busy = 1'b0; ctl_pkt_end = 1'b1;
    step(1);
    ctl_pkt_end = 1'b0;
    chk("R6", "disc after end", disc_nop_req, 1);
    for (int i = 0; i < 200; i++) begin
      if (!disc_nop_req) break;
      step(1);
    end
    // receiver checks while parked
    rx_tri_en = 1'b0; rx_disc_seen = 1'b1;
    step(1);
    chk("R8", "rx ignores without tri", rx_rcv_en, 1);
    rx_tri_en = 1'b1;
    step(1);
    rx_disc_seen = 1'b0;
    chk("R8", "rx off", rx_rcv_en, 0);
    step(1);
    chk("R8", "rx stays off", rx_rcv_en, 0);
    stop_n = 1'b1;
    step(1);
    chk("R8", "rx back", rx_rcv_en, 1);
    rx_tri_en = 1'b0;
    step(1);
  endtask

  task automatic t_override();
    stop_n = 1'b0;
    step(3);
    chk("R11", "mid disc", disc_nop_req, 1);
    reset_n = 1'b0;
    step(1);
    chk("R11", "reset wins", rst_active, 1);
    chk("R11", "disc ended", disc_nop_req, 0);
    chk("R2", "warm kind", rst_kind, K_WARM);
    reset_n = 1'b1; stop_n = 1'b1;
    step(1);
    chk("R11", "restart", init_start, 1);
    step(1);
  endtask

  initial begin
    t_cold_bringup();
    t_warm();
    t_sw(1'b1);
    t_sw(1'b0);
    t_pwr_drop();
    t_stop(1'b1);
    t_stop(1'b0);
    t_drain();
    t_override();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule